// File: doc/BRIEF.md
# SPI Command Front End for a CAN Controller Register Space

This block is the serial slave that sits between a host SPI master and the 128-byte register space of a small CAN controller. It works in SPI mode 0 (clock idles low, data sampled on the rising edge and shifted on the falling edge). The SPI pins are brought into the system clock domain and decoded there. The host frames each command with chip select. The first byte is an instruction, and the bytes after it are addresses, masks or data, depending on the instruction.

Six instructions are understood: device reset, register read, register write, masked bit update, transmit request and fast receive-buffer read. Reads and writes step the register address up by one after every data byte. A few locations have their own behaviour:
- a mode request register and a read-only status register that reports the live mode and an encoded interrupt source;
- an interrupt enable register;
- an interrupt flag register that the protocol engine can set through side-band pulses;
- three transmit control registers whose request bits leave the block as `tx_req` and are cleared by `tx_done` pulses.

When a fast receive-buffer read is closed by chip select rising, the receive flag of the buffer that was read is cleared.

Top module: `canspi_front`

## Requirements
- R1: After reset, control register 0x0F reads 0x80, status register 0x0E reads 0x80 (mode 100 = configuration, interrupt code 000), registers 0x2B, 0x2C, 0x30, 0x40, 0x50 and all plain locations read 0x00, `tx_req` is 000, `irq` is low and `cur_mode` is 100.
- R2: Instruction 0x02, then an address byte, then one or more data bytes writes the bytes to consecutive addresses. Only address bits 6:0 are used, and the address wraps from 0x7F to 0x00.
- R3: Instruction 0x03, then an address byte, returns the register contents MSB first on MISO, one byte per following byte time, with the address stepping up after each byte.
- R4: Instruction 0x05, then address, mask and data bytes, stores (old & ~mask) | (data & mask) at addresses 0x0F, 0x2B, 0x2C, 0x30, 0x40, 0x50, 0x60 and 0x70. At any other address it stores the data byte in full.
- R5: Bits 7:5 of register 0x0F request a mode: 000 normal, 001 sleep, 010 loopback, 011 listen-only, 100 configuration. The current mode appears on `cur_mode` and in status bits 7:5. A request of 101, 110 or 111 leaves the current mode unchanged.
- R6: Status register 0x0E is read-only. It reads {mode[2:0], 0, code[2:0], 0}, and a write to it has no effect.
- R7: The interrupt code in status bits 3:1 is formed from the flags in 0x2C ANDed with the enables in 0x2B. Sources are taken in this order of precedence: bit 5 gives 001, bit 6 gives 010, bit 2 gives 011, bit 3 gives 100, bit 4 gives 101, bit 0 gives 110, bit 1 gives 111. With none of these pending the code is 000.
- R8: Instruction 1000_0nnn sets bit 3 of transmit control register 0x30, 0x40 or 0x50 for each set bit n = 0, 1, 2. `tx_req[n]` mirrors that bit. A pulse on `tx_done[n]` clears it.
- R9: Instruction 1001_0nm0 returns data at once, with no address byte. It starts at 0x61 for nm=00, 0x66 for 01, 0x71 for 10 and 0x76 for 11, and steps up from there.
- R10: When chip select rises after a fast receive-buffer read, flag bit 0 of 0x2C is cleared if n=0, or flag bit 1 if n=1. An ordinary read leaves the flags unchanged.
- R11: Instruction 0xC0 returns every register, the mode and `tx_req` to the R1 state.
- R12: A pulse on `flag_set[i]` sets bit i of 0x2C. `irq` is high exactly when (0x2C & 0x2B) is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also used to sample the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI clock from the host, mode 0 |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, driven low while deselected |
| flag_set | input | 8 | One-cycle pulses that set interrupt flag bits |
| tx_done | input | 3 | One-cycle pulses that clear transmit requests |
| tx_req | output | 3 | Transmit request bit of each transmit buffer |
| irq | output | 1 | High while any enabled interrupt flag is set |
| cur_mode | output | 3 | Current operating mode |

## Verification
Plain storage is tested with address-dependent byte patterns written both singly and in bursts, so that lost increments, swapped addresses and a missing wrap all show up as wrong data at a known location. The masked update is run with a chain of mask and data pairs, and each result becomes the next starting value. This separates a correct merge from a plain overwrite or an inverted mask, and a second case checks that the full write still applies outside the masked set. The interrupt code is checked against every single-bit flag and a set of multi-bit flags under several enable masks, which exposes any wrong order of precedence or any source that is not gated by its enable. Each of the four fast-read starting points is read with both receive flags set, which shows both the starting address and which flag the release of chip select clears.

// File: rtl/canspi_pkg.sv
// Shared constants, types and address helpers for the CAN SPI front end.
// Assumes a 7-bit register address space and three transmit buffers.
package canspi_pkg;

    localparam int ADDR_W     = 7;
    localparam int NUM_TX     = 3;
    localparam int TX_STRIDE  = 16;
    localparam int TXREQ_BIT  = 3;
    localparam int NUM_CODES  = 7;

    localparam logic [6:0] A_STAT = 7'h0E;
    localparam logic [6:0] A_CTRL = 7'h0F;
    localparam logic [6:0] A_IEN  = 7'h2B;
    localparam logic [6:0] A_IFLG = 7'h2C;
    localparam logic [6:0] A_TXC0 = 7'h30;
    localparam logic [6:0] A_RXC0 = 7'h60;
    localparam logic [6:0] A_RXC1 = 7'h70;

    localparam logic [6:0] FAST_BASE = 7'h61;
    localparam logic [6:0] FAST_BUF  = 7'd16;
    localparam logic [6:0] FAST_HALF = 7'd5;

    localparam logic [2:0] MODE_CFG = 3'b100;
    localparam logic [7:0] CTRL_RST = 8'h80;

    localparam logic [7:0] OP_RESET = 8'hC0;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_BMOD  = 8'h05;

    typedef enum logic [2:0] {
        ST_OP, ST_ADDR, ST_MASK, ST_WR, ST_MOD, ST_RD, ST_SKIP
    } cmd_st_t;

    typedef enum logic [1:0] {K_RD, K_WR, K_BM} cmd_kind_t;

    // Address of transmit control register i
    function automatic logic [6:0] txc_addr(input int i);
        return A_TXC0 + 7'(i * TX_STRIDE);
    endfunction

    // True where the masked update merges instead of overwriting
    function automatic logic masked_ok(input logic [6:0] a);
        return (a == A_CTRL) || (a == A_IEN) || (a == A_IFLG) ||
               (a == txc_addr(0)) || (a == txc_addr(1)) || (a == txc_addr(2)) ||
               (a == A_RXC0) || (a == A_RXC1);
    endfunction

endpackage

// File: rtl/canspi_link.sv
// SPI mode 0 byte framer, oversampled in the system clock domain.
// Assumes the SPI clock is at most about a tenth of clk; SYNC flops per pin.
module canspi_link #(
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       csn,
    input  logic       mosi,
    input  logic [7:0] tx_byte,
    output logic       miso,
    output logic       active,
    output logic       byte_done,
    output logic [7:0] rx_byte,
    output logic       cs_rise
);
    localparam int CW = SYNC + 1;

    logic [CW-1:0] sck_s, csn_s, mosi_s;
    logic [2:0]    bit_cnt;
    logic [7:0]    rx_sr, tx_sr;
    logic          rise, fall;

    // Bring the SPI pins into the clk domain, one extra stage for edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_s  <= '0;
            csn_s  <= '1;
            mosi_s <= '0;
        end else begin
            sck_s  <= {sck_s[CW-2:0], sck};
            csn_s  <= {csn_s[CW-2:0], csn};
            mosi_s <= {mosi_s[CW-2:0], mosi};
        end
    end

    assign rise    = sck_s[SYNC-1] & ~sck_s[SYNC];
    assign fall    = ~sck_s[SYNC-1] & sck_s[SYNC];
    assign active  = ~csn_s[SYNC-1];
    assign cs_rise = csn_s[SYNC-1] & ~csn_s[SYNC];

    // Shift in on rising edges, shift out or reload on falling edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!active) begin
                bit_cnt <= '0;
                tx_sr   <= '0;
            end else begin
                if (rise) begin
                    rx_sr   <= {rx_sr[6:0], mosi_s[SYNC-1]};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) byte_done <= 1'b1;
                end
                if (fall) begin
                    if (bit_cnt == 3'd0) tx_sr <= tx_byte;
                    else                 tx_sr <= {tx_sr[6:0], 1'b0};
                end
            end
        end
    end

    assign rx_byte = rx_sr;
    assign miso    = active & tx_sr[7];

endmodule

// File: rtl/canspi_cmd.sv
// Instruction decoder: walks through opcode, address, mask and data bytes.
// Assumes byte_done pulses once per received byte while chip select is low.
module canspi_cmd
    import canspi_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          byte_done,
    input  logic [7:0]    rx_byte,
    input  logic          cs_rise,
    output logic [AW-1:0] ptr,
    output logic          we,
    output logic          wmasked,
    output logic [7:0]    wmask,
    output logic          soft_rst,
    output logic          rts_pulse,
    output logic [2:0]    rts_bits,
    output logic [1:0]    rx_clr
);
    cmd_st_t   st;
    cmd_kind_t kind;
    logic      clr_arm, clr_buf, at_op;

    assign at_op     = byte_done && (st == ST_OP);
    assign we        = byte_done && ((st == ST_WR) || (st == ST_MOD));
    assign wmasked   = (st == ST_MOD);
    assign soft_rst  = at_op && (rx_byte == OP_RESET);
    assign rts_pulse = at_op && (rx_byte[7:3] == 5'b10000);
    assign rts_bits  = rx_byte[2:0];
    assign rx_clr    = (cs_rise && clr_arm) ? (clr_buf ? 2'b10 : 2'b01) : 2'b00;

    // Sequence through the bytes of one chip-select frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_OP;
            kind    <= K_RD;
            ptr     <= '0;
            wmask   <= '0;
            clr_arm <= 1'b0;
            clr_buf <= 1'b0;
        end else if (!active) begin
            st      <= ST_OP;
            clr_arm <= 1'b0;
        end else if (byte_done) begin
            case (st)
                ST_OP: begin
                    casez (rx_byte)
                        OP_READ:      begin st <= ST_ADDR; kind <= K_RD; end
                        OP_WRITE:     begin st <= ST_ADDR; kind <= K_WR; end
                        OP_BMOD:      begin st <= ST_ADDR; kind <= K_BM; end
                        8'b1001_0??0: begin
                            st      <= ST_RD;
                            ptr     <= FAST_BASE + (rx_byte[2] ? FAST_BUF : 7'd0)
                                                 + (rx_byte[1] ? FAST_HALF : 7'd0);
                            clr_arm <= 1'b1;
                            clr_buf <= rx_byte[2];
                        end
                        default:      st <= ST_SKIP;
                    endcase
                end
                ST_ADDR: begin
                    ptr <= rx_byte[AW-1:0];
                    st  <= (kind == K_RD) ? ST_RD : (kind == K_WR) ? ST_WR : ST_MASK;
                end
                ST_MASK: begin
                    wmask <= rx_byte;
                    st    <= ST_MOD;
                end
                ST_WR, ST_RD: ptr <= ptr + 1'b1;
                ST_MOD:       st  <= ST_SKIP;
                default:      ;
            endcase
        end
    end

endmodule

// File: rtl/canspi_irq_prio.sv
// Priority encoder for the status interrupt code and the interrupt line.
// Assumes the flag bit layout fixed by the package.
module canspi_irq_prio
    import canspi_pkg::*;
(
    input  logic [7:0] flags,
    input  logic [7:0] ien,
    output logic [2:0] icode,
    output logic       irq
);
    logic [7:0] pend;

    // Flag bit reported by code k+1, highest precedence first
    function automatic int src_bit(input int k);
        case (k)
            0:       return 5;
            1:       return 6;
            2:       return 2;
            3:       return 3;
            4:       return 4;
            5:       return 0;
            default: return 1;
        endcase
    endfunction

    // Scan from lowest to highest precedence so the highest wins
    always_comb begin
        pend  = flags & ien;
        icode = '0;
        for (int k = NUM_CODES - 1; k >= 0; k--) begin
            if (pend[src_bit(k)]) icode = 3'(k + 1);
        end
    end

    assign irq = |pend;

endmodule

// File: rtl/canspi_regs.sv
// Register array with the mode, status, flag and transmit-control behaviour.
// Assumes at most one SPI write per cycle; side-band set beats clear.
module canspi_regs
    import canspi_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int NTX = NUM_TX
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          wmasked,
    input  logic [7:0]    wmask,
    input  logic [AW-1:0] raddr,
    input  logic          rts_pulse,
    input  logic [2:0]    rts_bits,
    input  logic [NTX-1:0] tx_done,
    input  logic [1:0]    rx_clr,
    input  logic [7:0]    flag_set,
    input  logic [2:0]    icode,
    output logic [7:0]    rd_data,
    output logic [7:0]    flags_q,
    output logic [7:0]    ien_q,
    output logic [NTX-1:0] tx_req,
    output logic [2:0]    mode_q
);
    localparam int DEPTH = 1 << AW;

    logic [7:0]           mem [DEPTH];
    logic [7:0]           wval, flag_nxt;
    logic [NTX-1:0][7:0]  txc_nxt;
    logic [2:0]           mode_req;

    // Value an SPI write stores: merged under mask where allowed
    always_comb begin
        if (wmasked && masked_ok(waddr))
            wval = (mem[waddr] & ~wmask) | (wdata & wmask);
        else
            wval = wdata;
    end

    // Next flag byte: write, then receive clears, then side-band sets
    always_comb begin
        flag_nxt = (we && waddr == A_IFLG) ? wval : mem[A_IFLG];
        flag_nxt = (flag_nxt & ~{6'b0, rx_clr}) | flag_set;
    end

    // Next transmit control bytes: write, then done clears, then requests set
    always_comb begin
        for (int i = 0; i < NTX; i++) begin
            txc_nxt[i] = (we && waddr == txc_addr(i)) ? wval : mem[txc_addr(i)];
            if (tx_done[i])                 txc_nxt[i][TXREQ_BIT] = 1'b0;
            if (rts_pulse && rts_bits[i])   txc_nxt[i][TXREQ_BIT] = 1'b1;
        end
    end

    // Transmit request outputs mirror the control bits
    always_comb begin
        for (int i = 0; i < NTX; i++) tx_req[i] = mem[txc_addr(i)][TXREQ_BIT];
    end

    assign mode_req = mem[A_CTRL][7:5];

    // Register storage and the current mode
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= (i == int'(A_CTRL)) ? CTRL_RST : 8'h00;
            mode_q <= MODE_CFG;
        end else begin
            if (we && waddr != A_STAT) mem[waddr] <= wval;
            mem[A_IFLG] <= flag_nxt;
            for (int i = 0; i < NTX; i++) mem[txc_addr(i)] <= txc_nxt[i];
            if (mode_req <= MODE_CFG) mode_q <= mode_req;
        end
    end

    assign flags_q = mem[A_IFLG];
    assign ien_q   = mem[A_IEN];
    assign rd_data = (raddr == A_STAT) ? {mode_q, 1'b0, icode, 1'b0} : mem[raddr];

endmodule

// File: rtl/canspi_front.sv
// Top level: SPI framer, instruction decoder, register bank and interrupt encoder.
// Assumes spi_* pins are asynchronous to clk and slow relative to it.
module canspi_front
    import canspi_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int NTX  = NUM_TX,
    parameter int SYNC = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           spi_sck,
    input  logic           spi_csn,
    input  logic           spi_mosi,
    output logic           spi_miso,
    input  logic [7:0]     flag_set,
    input  logic [NTX-1:0] tx_done,
    output logic [NTX-1:0] tx_req,
    output logic           irq,
    output logic [2:0]     cur_mode
);
    logic          active, byte_done, cs_rise;
    logic [7:0]    rx_byte, rd_data, wmask, flags_q, ien_q;
    logic [AW-1:0] ptr;
    logic          we, wmasked, soft_rst, rts_pulse;
    logic [2:0]    rts_bits, icode;
    logic [1:0]    rx_clr;

    canspi_link #(.SYNC(SYNC)) u_link (
        .clk(clk), .rst_n(rst_n), .sck(spi_sck), .csn(spi_csn), .mosi(spi_mosi),
        .tx_byte(rd_data), .miso(spi_miso), .active(active),
        .byte_done(byte_done), .rx_byte(rx_byte), .cs_rise(cs_rise)
    );

    canspi_cmd #(.AW(AW)) u_cmd (
        .clk(clk), .rst_n(rst_n), .active(active), .byte_done(byte_done),
        .rx_byte(rx_byte), .cs_rise(cs_rise), .ptr(ptr), .we(we),
        .wmasked(wmasked), .wmask(wmask), .soft_rst(soft_rst),
        .rts_pulse(rts_pulse), .rts_bits(rts_bits), .rx_clr(rx_clr)
    );

    canspi_regs #(.AW(AW), .NTX(NTX)) u_regs (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .we(we), .waddr(ptr),
        .wdata(rx_byte), .wmasked(wmasked), .wmask(wmask), .raddr(ptr),
        .rts_pulse(rts_pulse), .rts_bits(rts_bits), .tx_done(tx_done),
        .rx_clr(rx_clr), .flag_set(flag_set), .icode(icode), .rd_data(rd_data),
        .flags_q(flags_q), .ien_q(ien_q), .tx_req(tx_req), .mode_q(cur_mode)
    );

    canspi_irq_prio u_prio (
        .flags(flags_q), .ien(ien_q), .icode(icode), .irq(irq)
    );

endmodule

// File: rtl/canspi_front_chk.sv
// Assertion checker bound to canspi_front; observes decoder and register bank.
module canspi_front_chk
    import canspi_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rts_pulse,
    input logic [2:0] rts_bits,
    input logic [2:0] tx_done,
    input logic [2:0] tx_req,
    input logic       we,
    input logic [6:0] ptr,
    input logic       soft_rst,
    input logic [1:0] rx_clr,
    input logic [7:0] flag_set,
    input logic [7:0] flags_q,
    input logic [2:0] cur_mode
);
    // R8: a transmit request instruction raises the selected outputs
    p_rts_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rts_pulse |=> ((tx_req & $past(rts_bits)) == $past(rts_bits)));

    // R8: a done pulse clears its request when nothing else touches it
    p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done != 3'b0 && !rts_pulse && !we) |=> ((tx_req & $past(tx_done)) == 3'b0));

    // R5: the current mode never takes an undefined code
    p_mode_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cur_mode <= MODE_CFG);

    // R10: releasing chip select after a fast read of buffer 0 clears its flag
    p_rxclr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_clr[0] && !flag_set[0] && !(we && ptr == A_IFLG)) |=> !flags_q[0]);

    // R12: side-band pulses always land in the flag register
    p_flag_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set != 8'h00 && !soft_rst) |=> ((flags_q & $past(flag_set)) == $past(flag_set)));

    // R11: the reset instruction drops all requests and returns to configuration
    p_softrst_r11: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (tx_req == 3'b0 && cur_mode == MODE_CFG));

endmodule

bind canspi_front canspi_front_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rts_pulse(rts_pulse), .rts_bits(rts_bits),
    .tx_done(tx_done), .tx_req(tx_req), .we(we), .ptr(ptr),
    .soft_rst(soft_rst), .rx_clr(rx_clr), .flag_set(flag_set),
    .flags_q(flags_q), .cur_mode(cur_mode)
);

// File: tb/sim_canspi_front.sv
// Self-checking bench for canspi_front, driving SPI mode 0 frames.
module sim_canspi_front;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int WD_CYCLES  = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic       miso;
    logic [7:0] flag_set = 8'h00;
    logic [2:0] tx_done = 3'b000;
    logic [2:0] tx_req;
    logic       irq;
    logic [2:0] cur_mode;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    canspi_front u0 (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
        .spi_miso(miso), .flag_set(flag_set), .tx_done(tx_done),
        .tx_req(tx_req), .irq(irq), .cur_mode(cur_mode)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            ticks(HALF);
            sck   = 1'b1;
            rx[i] = miso;
            ticks(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic cs_on;
        csn = 1'b0;
        ticks(HALF);
    endtask

    task automatic cs_off;
        ticks(HALF);
        csn = 1'b1;
        ticks(3 * HALF);
    endtask

    task automatic wr1(input logic [7:0] a, input logic [7:0] d);
        logic [7:0] r;
        cs_on;
        spi_byte(8'h02, r); spi_byte(a, r); spi_byte(d, r);
        cs_off;
    endtask

    task automatic rd1(input logic [7:0] a, output logic [7:0] d);
        logic [7:0] r;
        cs_on;
        spi_byte(8'h03, r); spi_byte(a, r); spi_byte(8'h00, d);
        cs_off;
    endtask

    task automatic bmod(input logic [7:0] a, input logic [7:0] m, input logic [7:0] d);
        logic [7:0] r;
        cs_on;
        spi_byte(8'h05, r); spi_byte(a, r); spi_byte(m, r); spi_byte(d, r);
        cs_off;
    endtask

    task automatic op1(input logic [7:0] op);
        logic [7:0] r;
        cs_on;
        spi_byte(op, r);
        cs_off;
    endtask

    function automatic logic [7:0] pat(input int sel, input logic [6:0] a);
        if (sel == 0) return 8'((int'(a) * 37 + 11) & 255);
        return {1'b0, a} ^ 8'h3C;
    endfunction

    task automatic wr_burst(input logic [7:0] a, input int n, input int sel);
        logic [7:0] r;
        cs_on;
        spi_byte(8'h02, r); spi_byte(a, r);
        for (int k = 0; k < n; k++) spi_byte(pat(sel, 7'(a + 8'(k))), r);
        cs_off;
    endtask

    task automatic rd_burst_chk(input string req, input logic [7:0] a, input int n, input int sel);
        logic [7:0] r;
        cs_on;
        spi_byte(8'h03, r); spi_byte(a, r);
        for (int k = 0; k < n; k++) begin
            spi_byte(8'h00, r);
            chk(req, "burst read", r, pat(sel, 7'(a + 8'(k))));
        end
        cs_off;
    endtask

    function automatic logic [2:0] exp_code(input logic [7:0] f, input logic [7:0] e);
        logic [7:0] p;
        p = f & e;
        if (p[5]) return 3'd1;
        if (p[6]) return 3'd2;
        if (p[2]) return 3'd3;
        if (p[3]) return 3'd4;
        if (p[4]) return 3'd5;
        if (p[0]) return 3'd6;
        if (p[1]) return 3'd7;
        return 3'd0;
    endfunction

    initial begin
        ticks(WD_CYCLES);
        total++;
        bad++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] r, old, m, d, e, p, ex;
        logic [2:0] mode;
        ticks(5);
        rst_n = 1'b1;
        ticks(5);

        // R1: reset state
        rd1(8'h0F, r); chk("R1", "ctrl", r, 8'h80);
        rd1(8'h0E, r); chk("R1", "status", r, 8'h80);
        rd1(8'h2C, r); chk("R1", "flags", r, 8'h00);
        rd1(8'h2B, r); chk("R1", "enables", r, 8'h00);
        rd1(8'h40, r); chk("R1", "txctrl1", r, 8'h00);
        rd1(8'h15, r); chk("R1", "plain", r, 8'h00);
        chk("R1", "tx_req", tx_req, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "cur_mode", cur_mode, 4);
        mode = 3'd4;

        // R2, R3: bursts, single writes and address wrap
        wr_burst(8'h10, 16, 0);
        rd_burst_chk("R3", 8'h10, 16, 0);
        for (int a = 0; a < 14; a++) wr1(8'(a), pat(1, 7'(a)));
        rd_burst_chk("R2", 8'h00, 14, 1);
        cs_on;
        spi_byte(8'h02, r); spi_byte(8'hFF, r); spi_byte(8'hA5, r); spi_byte(8'h5A, r);
        cs_off;
        rd1(8'h7F, r); chk("R2", "wrap last", r, 8'hA5);
        rd1(8'h00, r); chk("R2", "wrap first", r, 8'h5A);

        // R4: masked update chain at 0x2B, full write at 0x20
        old = 8'h3C;
        wr1(8'h2B, old);
        for (int k = 0; k < 8; k++) begin
            m = 8'((k * 53 + 15) & 255);
            d = 8'((k * 107) & 255) ^ 8'hA5;
            bmod(8'h2B, m, d);
            ex = (old & ~m) | (d & m);
            rd1(8'h2B, r); chk("R4", "masked merge", r, ex);
            old = ex;
        end
        wr1(8'h2B, 8'h00);
        wr1(8'h20, 8'hF0);
        bmod(8'h20, 8'h0F, 8'h33);
        rd1(8'h20, r); chk("R4", "unmasked address full write", r, 8'h33);

        // R5: every mode request, illegal ones ignored
        for (int v = 0; v < 8; v++) begin
            wr1(8'h0F, 8'(v << 5));
            if (v <= 4) mode = 3'(v);
            ticks(4);
            rd1(8'h0E, r); chk("R5", "status mode", r[7:5], mode);
            chk("R5", "cur_mode", cur_mode, mode);
        end

        // R6: status register ignores writes
        wr1(8'h0E, 8'hFF);
        rd1(8'h0E, r); chk("R6", "status after write", r, {mode, 5'b0});

        // R8: transmit requests and done pulses
        op1(8'h85);
        chk("R8", "tx_req after 0x85", tx_req, 3'b101);
        rd1(8'h30, r); chk("R8", "txctrl0", r, 8'h08);
        rd1(8'h40, r); chk("R8", "txctrl1", r, 8'h00);
        rd1(8'h50, r); chk("R8", "txctrl2", r, 8'h08);
        tx_done = 3'b001; ticks(1); tx_done = 3'b000; ticks(2);
        chk("R8", "tx_done clears 0", tx_req, 3'b100);
        op1(8'h82);
        chk("R8", "tx_req after 0x82", tx_req, 3'b110);
        tx_done = 3'b111; ticks(1); tx_done = 3'b000; ticks(2);
        chk("R8", "tx_done clears all", tx_req, 3'b000);

        // R7, R12: interrupt code and line over flag and enable patterns
        for (int j = 0; j < 20; j++) begin
            p = (j < 8) ? 8'(1 << j) : 8'(((j - 8) * 77 + 33) & 255);
            e = (j % 3 == 0) ? 8'hFF : (j % 3 == 1) ? 8'hDB : 8'h7E;
            wr1(8'h2B, e);
            wr1(8'h2C, p);
            rd1(8'h0E, r);
            chk("R7", "interrupt code", r, {mode, 1'b0, exp_code(p, e), 1'b0});
            chk("R12", "irq line", irq, int'((p & e) != 8'h00));
        end
        wr1(8'h2C, 8'h00);
        flag_set = 8'h41; ticks(1); flag_set = 8'h00; ticks(2);
        rd1(8'h2C, r); chk("R12", "side-band set", r, 8'h41);
        wr1(8'h2B, 8'h00);

        // R9, R10: fast reads from each start point and flag release
        wr_burst(8'h61, 10, 1);
        wr_burst(8'h71, 10, 1);
        for (int nm = 0; nm < 4; nm++) begin
            logic [6:0] st;
            st = 7'h61 + ((nm >= 2) ? 7'd16 : 7'd0) + ((nm % 2 == 1) ? 7'd5 : 7'd0);
            wr1(8'h2C, 8'h03);
            cs_on;
            spi_byte(8'h90 | 8'(nm << 1), r);
            for (int k = 0; k < 3; k++) begin
                spi_byte(8'h00, r);
                chk("R9", "fast read data", r, pat(1, st + 7'(k)));
            end
            cs_off;
            rd1(8'h2C, r);
            chk("R10", "flag after fast read", r, (nm >= 2) ? 8'h01 : 8'h02);
        end
        wr1(8'h2C, 8'h03);
        rd1(8'h61, r);
        rd1(8'h2C, r); chk("R10", "ordinary read keeps flags", r, 8'h03);

        // R11: reset instruction
        op1(8'h87);
        chk("R11", "tx_req before reset", tx_req, 3'b111);
        op1(8'hC0);
        chk("R11", "tx_req", tx_req, 3'b000);
        chk("R11", "cur_mode", cur_mode, 4);
        rd1(8'h0F, r); chk("R11", "ctrl", r, 8'h80);
        rd1(8'h10, r); chk("R11", "plain", r, 8'h00);
        rd1(8'h2C, r); chk("R11", "flags", r, 8'h00);
        rd1(8'h0E, r); chk("R11", "status", r, 8'h80);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule